// File: doc/BRIEF.md
# Warp Lane-Enable Divergence Stack

This block holds the lane-enable mask of a warp whose lanes all receive the same instruction in the same cycle. A lane with a clear bit ignores the instruction. When a branch splits the currently enabled lanes into two non-empty groups, the block records the split. It enables the taken group at once and keeps the untaken group and the pre-branch mask for later. Each path-done event advances to the next pending mask. The first such event after a split enables the untaken group. The second restores the mask that was live before the branch.

A branch whose taken vector selects all or none of the enabled lanes is uniform. It records nothing, and the warp carries on with its mask unchanged. Splits nest up to a parameterised depth. A split that arrives when every level is in use raises an error flag. That flag stays set until reset, and the split itself is dropped. All outputs are registered and change on the clock edge that samples the event.

Top module: `simt_mask_stack`

## Requirements
- R1: Reset, synchronous and active high, sets lane_mask to all ones, lanes_live to 1 and stack_overflow to 0, and empties the stack.
- R2: A divergent branch (enabled lanes in both groups) makes lane_mask equal to the old mask AND branch_taken on the next edge. Bit i is lane i. A branch never enables a lane that was disabled.
- R3: A divergent branch that arrives while DEPTH splits are open sets stack_overflow and leaves lane_mask and the stack unchanged.
- R4: The first path_done after a split sets lane_mask to the pre-branch mask AND NOT branch_taken.
- R5: The second path_done after a split restores the exact pre-branch mask.
- R6: A uniform branch, where the old mask AND branch_taken is zero or the old mask AND NOT branch_taken is zero, leaves lane_mask unchanged and records no level.
- R7: Nested splits unwind last-in first-out. Each inner split resolves fully before its enclosing split moves to its second path.
- R8: path_done with no open split leaves lane_mask unchanged.
- R9: If branch_valid and path_done are high in the same cycle, the branch is applied and the path_done is ignored.
- R10: lanes_live is 1 exactly when lane_mask has at least one bit set.
- R11: Once set, stack_overflow stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| branch_valid | input | 1 | Branch event this cycle |
| branch_taken | input | LANES | Per-lane taken vector of the branch |
| path_done | input | 1 | The current path has finished, or reconvergence has been reached |
| lane_mask | output | LANES | Current per-lane enable |
| lanes_live | output | 1 | At least one lane is enabled |
| stack_overflow | output | 1 | Sticky error: a split was dropped because the stack was full |

## Verification
A branch and a path-done event can fall in the same cycle. The bench raises both together while a split is open and also while the stack is empty. It judges the result by the mask on the next edge and by the masks produced by the later path-done events, which must show that the ignored pop did not consume a level. The same collisions come up again in a long random stream. There, a behavioural queue model checks mask, live flag and overflow flag after every edge, including the cycles where overflow and pops interleave.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD    = 3'd0,
    ACT_PUSH    = 3'd1,
    ACT_OTHER   = 3'd2,
    ACT_RESTORE = 3'd3,
    ACT_OVF     = 3'd4
  } stack_act_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/simt_div_split.sv
module simt_div_split #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] taken_mask,
  output logic [LANES-1:0] other_mask,
  output logic             diverge
);
  always_comb begin
    taken_mask = cur_mask & taken;
    other_mask = cur_mask & ~taken;
    diverge    = (|taken_mask) && (|other_mask);
  end
endmodule

// File: rtl/simt_seq_decide.sv
module simt_seq_decide
  import simt_pkg::*;
(
  input  logic       branch_valid,
  input  logic       path_done,
  input  logic       diverge,
  input  logic       full,
  input  logic       empty,
  input  logic       top_second,
  output stack_act_e act
);
  always_comb begin
    act = ACT_HOLD;
    if (branch_valid) begin
      if (diverge) act = full ? ACT_OVF : ACT_PUSH;
    end else if (path_done && !empty) begin
      act = top_second ? ACT_RESTORE : ACT_OTHER;
    end
  end
endmodule

// File: rtl/simt_lifo_ram.sv
module simt_lifo_ram #(
  parameter int W     = 64,
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             branch_valid,
  input  logic [LANES-1:0] branch_taken,
  input  logic             path_done,
  output logic [LANES-1:0] lane_mask,
  output logic             lanes_live,
  output logic             stack_overflow
);
  localparam int AW = idx_width(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int EW = 2 * LANES;

  logic [LANES-1:0] mask_q, mask_d;
  logic [LW-1:0]    lvl_q;
  logic [DEPTH-1:0] second_q;
  logic             live_q, ovf_q;

  logic [LANES-1:0] tk_mask, nt_mask;
  logic             diverge;
  logic [AW-1:0]    waddr, raddr;
  logic [EW-1:0]    rd_entry;
  logic             full, empty, ram_we;
  stack_act_e       act;

  assign waddr = lvl_q[AW-1:0];
  assign raddr = waddr - AW'(1);
  assign full  = (lvl_q == LW'(DEPTH));
  assign empty = (lvl_q == '0);

  simt_div_split #(.LANES(LANES)) u_split (
    .cur_mask   (mask_q),
    .taken      (branch_taken),
    .taken_mask (tk_mask),
    .other_mask (nt_mask),
    .diverge    (diverge)
  );

  simt_seq_decide u_decide (
    .branch_valid (branch_valid),
    .path_done    (path_done),
    .diverge      (diverge),
    .full         (full),
    .empty        (empty),
    .top_second   (second_q[raddr]),
    .act          (act)
  );

  assign ram_we = (act == ACT_PUSH);

  simt_lifo_ram #(.W(EW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (waddr),
    .wdata ({mask_q, nt_mask}),
    .raddr (raddr),
    .rdata (rd_entry)
  );

  always_comb begin
    case (act)
      ACT_PUSH:    mask_d = tk_mask;
      ACT_OTHER:   mask_d = rd_entry[LANES-1:0];
      ACT_RESTORE: mask_d = rd_entry[EW-1:LANES];
      default:     mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '1;
      live_q   <= 1'b1;
      lvl_q    <= '0;
      second_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      live_q <= |mask_d;
      case (act)
        ACT_PUSH: begin
          second_q[waddr] <= 1'b0;
          lvl_q           <= lvl_q + LW'(1);
        end
        ACT_OTHER:   second_q[raddr] <= 1'b1;
        ACT_RESTORE: lvl_q <= lvl_q - LW'(1);
        ACT_OVF:     ovf_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign lane_mask      = mask_q;
  assign lanes_live     = live_q;
  assign stack_overflow = ovf_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             branch_valid,
  input logic [LANES-1:0] branch_taken,
  input logic             path_done,
  input logic [LANES-1:0] lane_mask,
  input logic             lanes_live,
  input logic             stack_overflow
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (lane_mask == '1 && lanes_live && !stack_overflow));

  assert_branch_no_gain_R2: assert property (@(posedge clk) disable iff (rst)
    branch_valid |=> ((lane_mask & ~$past(lane_mask)) == '0));

  assert_overflow_holds_mask_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(stack_overflow) |-> $stable(lane_mask));

  assert_uniform_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (branch_valid && (((lane_mask & branch_taken) == '0) ||
                      ((lane_mask & ~branch_taken) == '0))) |=> $stable(lane_mask));

  assert_live_flag_R10: assert property (@(posedge clk) disable iff (rst)
    lanes_live == (lane_mask != '0));

  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    stack_overflow |=> stack_overflow);
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .branch_valid   (branch_valid),
  .branch_taken   (branch_taken),
  .path_done      (path_done),
  .lane_mask      (lane_mask),
  .lanes_live     (lanes_live),
  .stack_overflow (stack_overflow)
);

// File: tb/test_simt_mask_stack.sv
module test_simt_mask_stack;
  localparam int LANES = 32;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             branch_valid = 1'b0;
  logic [LANES-1:0] branch_taken = '0;
  logic             path_done = 1'b0;
  logic [LANES-1:0] lane_mask;
  logic             lanes_live;
  logic             stack_overflow;

  int n_checks = 0;
  int n_fails  = 0;

  // behavioural model
  logic [LANES-1:0] m_mask;
  logic             m_ovf;
  logic [LANES-1:0] q_restore[$];
  logic [LANES-1:0] q_other[$];
  bit               q_second[$];

  always #5 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) i_simt_mask_stack (
    .clk(clk), .rst(rst), .branch_valid(branch_valid), .branch_taken(branch_taken),
    .path_done(path_done), .lane_mask(lane_mask), .lanes_live(lanes_live),
    .stack_overflow(stack_overflow)
  );

  task automatic chk(input string tag, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_mask = '1; m_ovf = 1'b0;
    q_restore.delete(); q_other.delete(); q_second.delete();
  endtask

  task automatic model_step(input logic b, input logic [LANES-1:0] t, input logic p);
    logic [LANES-1:0] tk, nt;
    tk = m_mask & t;
    nt = m_mask & ~t;
    if (b) begin
      if (tk != '0 && nt != '0) begin
        if (q_other.size() == DEPTH) m_ovf = 1'b1;
        else begin
          q_restore.push_back(m_mask); q_other.push_back(nt); q_second.push_back(1'b0);
          m_mask = tk;
        end
      end
    end else if (p && q_other.size() > 0) begin
      if (!q_second[$]) begin
        m_mask = q_other[$];
        q_second[$] = 1'b1;
      end else begin
        m_mask = q_restore[$];
        void'(q_restore.pop_back()); void'(q_other.pop_back()); void'(q_second.pop_back());
      end
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " mask"}, lane_mask, m_mask);
    chk({"R10 live"}, {31'b0, lanes_live}, {31'b0, (m_mask != '0)});
    chk({tag, " ovf"}, {31'b0, stack_overflow}, {31'b0, m_ovf});
  endtask

  task automatic step(input logic b, input logic [LANES-1:0] t, input logic p, input string tag);
    branch_valid = b; branch_taken = t; path_done = p;
    @(posedge clk);
    model_step(b, t, p);
    @(negedge clk);
    branch_valid = 1'b0; path_done = 1'b0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 mask", lane_mask, 32'hFFFF_FFFF);
    chk("R1 live", {31'b0, lanes_live}, 32'd1);
    chk("R1 ovf", {31'b0, stack_overflow}, 32'd0);

    // R8: pop on empty stack
    step(1'b0, '0, 1'b1, "R8");
    chk("R8 literal", lane_mask, 32'hFFFF_FFFF);

    // R2, R4, R5: simple split
    step(1'b1, 32'h0000_FFFF, 1'b0, "R2");
    chk("R2 literal", lane_mask, 32'h0000_FFFF);
    step(1'b0, '0, 1'b1, "R4");
    chk("R4 literal", lane_mask, 32'hFFFF_0000);
    step(1'b0, '0, 1'b1, "R5");
    chk("R5 literal", lane_mask, 32'hFFFF_FFFF);

    // R6: uniform branches
    step(1'b1, 32'hFFFF_FFFF, 1'b0, "R6");
    chk("R6 all-taken", lane_mask, 32'hFFFF_FFFF);
    step(1'b1, 32'h00FF_00FF, 1'b0, "R2");
    step(1'b1, 32'hFF00_FF00, 1'b0, "R6");
    chk("R6 none-taken", lane_mask, 32'h00FF_00FF);
    step(1'b0, '0, 1'b1, "R6");
    chk("R6 no level recorded", lane_mask, 32'hFF00_FF00);
    step(1'b0, '0, 1'b1, "R5");
    chk("R5 literal 2", lane_mask, 32'hFFFF_FFFF);

    // R7: nesting
    step(1'b1, 32'h0F0F_0F0F, 1'b0, "R7");
    step(1'b1, 32'h0000_0F0F, 1'b0, "R7");
    chk("R7 inner taken", lane_mask, 32'h0000_0F0F);
    step(1'b0, '0, 1'b1, "R7");
    chk("R7 inner other", lane_mask, 32'h0F0F_0000);
    step(1'b0, '0, 1'b1, "R7");
    chk("R7 inner restore", lane_mask, 32'h0F0F_0F0F);
    step(1'b0, '0, 1'b1, "R7");
    chk("R7 outer other", lane_mask, 32'hF0F0_F0F0);
    step(1'b0, '0, 1'b1, "R7");
    chk("R7 outer restore", lane_mask, 32'hFFFF_FFFF);

    // R9: branch and pop in the same cycle
    step(1'b1, 32'hAAAA_AAAA, 1'b1, "R9");
    chk("R9 branch wins", lane_mask, 32'hAAAA_AAAA);
    step(1'b1, 32'h0000_AAAA, 1'b1, "R9");
    chk("R9 nested branch wins", lane_mask, 32'h0000_AAAA);
    step(1'b0, '0, 1'b1, "R9");
    chk("R9 pop not consumed", lane_mask, 32'hAAAA_0000);
    step(1'b0, '0, 1'b1, "R9");
    step(1'b0, '0, 1'b1, "R9");
    chk("R9 outer other", lane_mask, 32'h5555_5555);
    step(1'b0, '0, 1'b1, "R9");
    chk("R9 back to full", lane_mask, 32'hFFFF_FFFF);

    // R3, R11: overflow
    step(1'b1, 32'h0000_FFFF, 1'b0, "R3");
    step(1'b1, 32'h0000_00FF, 1'b0, "R3");
    step(1'b1, 32'h0000_000F, 1'b0, "R3");
    step(1'b1, 32'h0000_0003, 1'b0, "R3");
    chk("R3 full no flag", {31'b0, stack_overflow}, 32'd0);
    step(1'b1, 32'h0000_0001, 1'b0, "R3");
    chk("R3 flag", {31'b0, stack_overflow}, 32'd1);
    chk("R3 mask held", lane_mask, 32'h0000_0003);
    step(1'b0, '0, 1'b1, "R3");
    chk("R3 stack intact", lane_mask, 32'h0000_000C);
    for (int i = 0; i < 7; i++) step(1'b0, '0, 1'b1, "R11");
    chk("R11 unwound", lane_mask, 32'hFFFF_FFFF);
    chk("R11 sticky", {31'b0, stack_overflow}, 32'd1);

    do_reset();
    chk("R1 ovf cleared", {31'b0, stack_overflow}, 32'd0);
    chk("R1 mask again", lane_mask, 32'hFFFF_FFFF);

    // random stream against the model
    for (int i = 0; i < 3000; i++) begin
      logic b, p;
      logic [LANES-1:0] t;
      b = ($urandom % 3) == 0;
      p = ($urandom % 2) == 0;
      t = $urandom;
      if (($urandom % 4) == 0) t = t & $urandom;
      step(b, t, p, "R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule